// File: doc/BRIEF.md
# Oversampling SPI Mode-0 Slave

This block is an SPI slave that runs entirely on the system clock. The external serial clock, the active-low select and the master-out data line are treated as ordinary inputs. Each passes through a two-stage synchroniser. Edges of the serial clock are then found by comparing the synchronised value with its value one cycle earlier. No flop in the block is ever clocked by the serial clock.

Data moves most significant bit first in mode 0. The slave captures master-out data on serial-clock rising edges and updates its master-in output after falling edges. The user side has two paths. A valid/ready handshake preloads one word for the slave to return. Each completely received word appears on a parallel output together with a one-cycle valid strobe.

A preloaded word moves into the transmit shifter at one of two points: when select is asserted, or on the falling edge that closes a word while select stays low. If no word is pending at either point, the slave shifts out zeros.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, `tx_ready_o` is 1, `rx_valid_o` is 0 and `miso_o` is 0.
- R2: While select is low, the bits on `mosi_i` at successive serial-clock rising edges are collected MSB first. After the W-th edge, `rx_data_o` holds the word and `rx_valid_o` is high for exactly one clock cycle.
- R3: A word preloaded before select falls appears on `miso_o` MSB first. Its MSB is present before the first rising edge. Each later bit appears after a falling edge and stays stable until the next falling edge.
- R4: A load happens in a cycle where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` is 0 from the next cycle on, until the word is moved into the shifter.
- R5: If no word is pending when a word starts, the slave returns all zeros on `miso_o`.
- R6: While select stays low, words follow back to back. A word loaded during one word is sent in the next word, and every word produces its own strobe.
- R7: Raising select part way through a word discards the partial bits without a strobe. The next transfer starts again at bit 0.
- R8: While select is high, serial-clock edges produce no strobe and do not advance the bit count, and `miso_o` stays 0.
- R9: `rx_valid_o` goes high at the third system-clock rising edge after the final serial-clock rising edge reaches the pin (two synchroniser stages and one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the master, sampled as data |
| sel_n_i | input | 1 | Slave select from the master, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_data_i | input | W | Word to return to the master |
| tx_valid_i | input | 1 | `tx_data_i` is offered for loading |
| tx_ready_o | output | 1 | No word is pending, so a load is accepted |
| rx_data_o | output | W | Last word received from the master |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_data_o` |

## Verification
The bench uses the default width W of 8 and drives the serial clock with a half period of six system cycles. That half period is long enough for the two synchroniser stages and the edge register to settle between pin changes. The ratio also brings within reach several timing-dependent cases:
- the exact three-cycle strobe latency after the last rising edge;
- a second word loaded while the first is still shifting;
- a select release after three bits;
- serial-clock activity while the slave is deselected.

With eight bits, the all-ones, all-zeros and alternating patterns each cover both MSB and LSB positions.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic sclk;
    logic sel_n;
    logic mosi;
  } spi_lines_t;

  localparam spi_lines_t LINES_IDLE = '{sclk: 1'b0, sel_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[g] <= RST_VAL;
        end else if (g == 0) begin
          stage_q[g] <= d_i;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sel_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_start,
  output logic sel_act
);

  logic sclk_d;
  logic sel_n_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sel_n_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      sel_n_d <= sel_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign sel_start = sel_n_d & ~sel_n_s;
  assign sel_act   = ~sel_n_s;

  // Two rising edges can never be detected in consecutive cycles.
  p_rise_spaced_r2: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/spi_os_shift.sv
module spi_os_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sel_start,
  input  logic         sel_act,
  input  logic         mosi_s,
  input  logic         pend_valid,
  input  logic [W-1:0] pend_data,
  output logic         take,
  output logic         miso_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] bit_cnt;
  logic          wrap;
  logic [W-1:0]  tx_sh;
  logic [W-2:0]  rx_sh;
  logic [W-1:0]  rx_nxt;
  logic [W-1:0]  tx_next_word;

  assign rx_nxt       = {rx_sh, mosi_s};
  assign tx_next_word = pend_valid ? pend_data : '0;
  assign take         = sel_act & (sel_start | (sclk_fall & wrap));
  assign miso_o       = tx_sh[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      wrap       <= 1'b0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!sel_act) begin
        bit_cnt <= '0;
        wrap    <= 1'b0;
        tx_sh   <= '0;
      end else if (sel_start) begin
        bit_cnt <= '0;
        wrap    <= 1'b0;
        tx_sh   <= tx_next_word;
      end else begin
        if (sclk_rise) begin
          rx_sh <= rx_nxt[W-2:0];
          if (bit_cnt == LAST) begin
            bit_cnt    <= '0;
            wrap       <= 1'b1;
            rx_data_o  <= rx_nxt;
            rx_valid_o <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + CW'(1);
          end
        end
        if (sclk_fall) begin
          if (wrap) begin
            tx_sh <= tx_next_word;
            wrap  <= 1'b0;
          end else begin
            tx_sh <= tx_sh << 1;
          end
        end
      end
    end
  end

  p_one_cycle_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  p_strobe_needs_select_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(sel_act));

  p_idle_miso_low_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> !miso_o);

  p_count_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> (bit_cnt == '0));

  p_miso_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_act && !sel_start && !sclk_fall) |=> $stable(miso_o));

endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         sel_n_i,
  input  logic         mosi_i,
  output logic         miso_o,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o
);

  import spi_os_pkg::*;

  spi_lines_t lines_raw;
  spi_lines_t lines_s;
  logic [$bits(spi_lines_t)-1:0] lines_q;

  logic sclk_rise, sclk_fall, sel_start, sel_act;
  logic take;
  logic pend_valid;
  logic [W-1:0] pend_data;
  logic load;

  assign lines_raw = '{sclk: sclk_i, sel_n: sel_n_i, mosi: mosi_i};

  spi_os_sync #(
    .N      ($bits(spi_lines_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_IDLE)
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d_i(lines_raw),
    .q_o(lines_q)
  );

  assign lines_s = spi_lines_t'(lines_q);

  spi_os_edge i_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (lines_s.sclk),
    .sel_n_s  (lines_s.sel_n),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .sel_start(sel_start),
    .sel_act  (sel_act)
  );

  spi_os_shift #(.W(W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sel_start (sel_start),
    .sel_act   (sel_act),
    .mosi_s    (lines_s.mosi),
    .pend_valid(pend_valid),
    .pend_data (pend_data),
    .take      (take),
    .miso_o    (miso_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  // Single-entry pending word holder.
  assign load       = tx_valid_i & ~pend_valid;
  assign tx_ready_o = ~pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else begin
      pend_valid <= load | (pend_valid & ~take);
      if (load) begin
        pend_data <= tx_data_i;
      end
    end
  end

  p_ready_drops_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  p_ready_returns_r4: assert property (@(posedge clk) disable iff (rst)
    (!tx_ready_o && take) |=> tx_ready_o);

  p_ready_held_r4: assert property (@(posedge clk) disable iff (rst)
    (!tx_ready_o && !take) |=> !tx_ready_o);

endmodule

// File: tb/test_spi_os_slave.sv
module test_spi_os_slave;

  localparam int W  = 8;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b0;
  logic sel_n_i = 1'b1;
  logic mosi_i = 1'b0;
  logic miso_o;
  logic [W-1:0] tx_data_i = '0;
  logic tx_valid_i = 1'b0;
  logic tx_ready_o;
  logic [W-1:0] rx_data_o;
  logic rx_valid_o;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  logic [W-1:0] rx_hist [4];

  always #5 clk = ~clk;

  spi_os_slave #(.W(W)) i_spi_os_slave (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sel_n_i(sel_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  always @(posedge clk) begin
    if (!rst && rx_valid_o) begin
      rx_hist[strobes % 4] <= rx_data_o;
      strobes <= strobes + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic preload(input logic [W-1:0] w);
    @(negedge clk);
    while (!tx_ready_o) @(negedge clk);
    tx_data_i  = w;
    tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  // Clocks n bits of mo (MSB first) with select already low.
  task automatic clock_bits(input logic [2*W-1:0] mo, input int n,
                            output logic [2*W-1:0] mi, output logic stable);
    mi = '0;
    stable = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = mo[i];
      idle(HP);
      sclk_i = 1'b1;
      mi[i] = miso_o;
      idle(HP - 1);
      if (miso_o !== mi[i]) stable = 1'b0;
      @(negedge clk);
      sclk_i = 1'b0;
    end
    idle(HP);
  endtask

  task automatic xfer(input logic [W-1:0] mo, output logic [W-1:0] mi, output logic stable);
    logic [2*W-1:0] m;
    sel_n_i = 1'b0;
    clock_bits({{W{1'b0}}, mo}, W, m, stable);
    mi = m[W-1:0];
    sel_n_i = 1'b1;
    idle(HP);
  endtask

  // {mosi word, miso preload, preload flag}
  localparam logic [2*W:0] VEC [6] = '{
    {8'hA5, 8'h3C, 1'b1},
    {8'hFF, 8'h00, 1'b1},
    {8'h00, 8'hFF, 1'b1},
    {8'h81, 8'h7E, 1'b1},
    {8'h5A, 8'hC9, 1'b0},
    {8'hC3, 8'h96, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] mi;
    logic [2*W-1:0] mi2;
    logic st;
    int base;

    idle(4);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready_o === 1'b1, "R1 ready", tx_ready_o, 1);
    chk(rx_valid_o === 1'b0, "R1 strobe", rx_valid_o, 0);
    chk(miso_o === 1'b0, "R1 miso", miso_o, 0);

    // Table-driven transfers: R2, R3, R4, R5
    for (int v = 0; v < 6; v++) begin
      logic [W-1:0] mo, pl, exp_mi;
      logic flag;
      {mo, pl, flag} = VEC[v];
      exp_mi = flag ? pl : '0;
      if (flag) begin
        preload(pl);
        chk(tx_ready_o === 1'b0, "R4 ready low after load", tx_ready_o, 0);
      end
      base = strobes;
      xfer(mo, mi, st);
      chk(strobes == base + 1, "R2 one strobe per word", strobes - base, 1);
      chk(rx_data_o === mo, "R2 received word", rx_data_o, mo);
      chk(mi === exp_mi, flag ? "R3 transmitted word" : "R5 zeros when nothing loaded", mi, exp_mi);
      chk(st === 1'b1, "R3 miso stable while clock high", st, 1);
      chk(tx_ready_o === 1'b1, "R4 ready back after word starts", tx_ready_o, 1);
    end

    // R9: strobe latency after final rising edge
    sel_n_i = 1'b0;
    clock_bits({8'h00, 8'h6D}, W - 1, mi2, st);
    mosi_i = 1'b1;
    idle(HP);
    sclk_i = 1'b1;
    @(negedge clk);
    chk(rx_valid_o === 1'b0, "R9 no strobe after 1 edge", rx_valid_o, 0);
    @(negedge clk);
    chk(rx_valid_o === 1'b0, "R9 no strobe after 2 edges", rx_valid_o, 0);
    @(negedge clk);
    chk(rx_valid_o === 1'b1, "R9 strobe after 3 edges", rx_valid_o, 1);
    chk(rx_data_o === 8'hDB, "R9 word", rx_data_o, 8'hDB);
    @(negedge clk);
    chk(rx_valid_o === 1'b0, "R2 strobe lasts one cycle", rx_valid_o, 0);
    idle(HP);
    sclk_i = 1'b0;
    idle(HP);
    sel_n_i = 1'b1;
    idle(HP);

    // R6: back-to-back words under one select
    preload(8'h1E);
    base = strobes;
    sel_n_i = 1'b0;
    idle(HP);
    chk(tx_ready_o === 1'b1, "R4 ready after select start", tx_ready_o, 1);
    preload(8'hB7);
    chk(tx_ready_o === 1'b0, "R6 second word pending", tx_ready_o, 0);
    clock_bits(16'h4CE2, 2 * W, mi2, st);
    sel_n_i = 1'b1;
    idle(HP);
    chk(strobes == base + 2, "R6 two strobes", strobes - base, 2);
    chk(rx_hist[base % 4] === 8'h4C, "R6 first word", rx_hist[base % 4], 8'h4C);
    chk(rx_hist[(base + 1) % 4] === 8'hE2, "R6 second word", rx_hist[(base + 1) % 4], 8'hE2);
    chk(mi2 === 16'h1EB7, "R6 transmitted pair", mi2, 16'h1EB7);

    // R7: partial word discarded
    base = strobes;
    sel_n_i = 1'b0;
    clock_bits(16'h0007, 3, mi2, st);
    sel_n_i = 1'b1;
    idle(HP);
    chk(strobes == base, "R7 no strobe for partial word", strobes - base, 0);
    xfer(8'h93, mi, st);
    chk(strobes == base + 1 && rx_data_o === 8'h93, "R7 realigned word", rx_data_o, 8'h93);

    // R8: clock activity while deselected
    base = strobes;
    st = 1'b1;
    for (int i = 0; i < 2 * W + 3; i++) begin
      mosi_i = i[0];
      idle(HP);
      sclk_i = 1'b1;
      idle(HP);
      sclk_i = 1'b0;
      if (miso_o !== 1'b0) st = 1'b0;
    end
    idle(HP);
    chk(strobes == base, "R8 no strobe while deselected", strobes - base, 0);
    chk(st === 1'b1, "R8 miso low while deselected", st, 1);
    xfer(8'h2F, mi, st);
    chk(strobes == base + 1 && rx_data_o === 8'h2F, "R8 count untouched", rx_data_o, 8'h2F);

    // R1: reset mid-pending
    preload(8'hAA);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready_o === 1'b1, "R1 ready after reset", tx_ready_o, 1);
    chk(miso_o === 1'b0, "R1 miso after reset", miso_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule